// File: doc/BRIEF.md
# Serially Programmed Clock Fanout Gate

This block is the control logic of a clock fanout buffer. One reference clock enters and drives twelve output pairs, each with a true pin and a complement pin, plus one feedback output. Every pair and the feedback output can be switched on or off through an SMBus block write. The block checks the slave address, reads the command byte and the byte count, and keeps the enable bits carried in two of the data bytes. The other data bytes are acknowledged and then dropped.

The `ddr_mode` pin decides what the complement pins of pairs 0 to 5 carry. When it is high they carry the inverted reference clock. When it is low they carry an in-phase copy of it. Pairs 6 to 11 always have an inverted complement. The active-low `pwr_dn_n` pin forces every clock output low at once.

An enable value that has been written is copied into the output domain only on a falling edge of the reference clock. A pin can therefore never be cut off partway through a high pulse.

The bus front end is a state machine clocked by the system clock. Its states are:
- ST_IDLE: waits for a start condition.
- ST_ADDR: receives the address byte.
- ST_CMD: receives the command byte.
- ST_COUNT: receives the byte count.
- ST_DATA: receives the data bytes.
- ST_ACK: holds the data line low for one bit time.
- ST_IGNORE: waits for the next start or stop.

Its transitions are:
- A start condition leads to ST_ADDR from any state.
- A stop condition leads to ST_IDLE from any state.
- At the clock fall that ends an accepted byte, the machine goes to ST_ACK. A refused byte leads to ST_IGNORE instead.
- ST_ACK returns to the next receive state at the following clock fall. The next receive state is ST_CMD after the address, ST_COUNT after the command, and ST_DATA after the count or after a data byte.

Top module: `clk_fanout_ctl`

## Requirements
- R1: After reset, all twelve pair enables and the feedback enable are active. With `pwr_dn_n` high, every true pin and the feedback output follow the reference clock.
- R2: An address byte whose upper seven bits are 1101001 and whose bit 0 (read/write) is 0 is acknowledged. Any other address is not acknowledged, and the enables stay unchanged.
- R3: After the address, the command byte and the count byte are each acknowledged. Data bytes are acknowledged while the count is not used up. Data bytes beyond the count are not acknowledged and are not stored.
- R4: Data bytes are numbered from 0 in arrival order. Bytes 0 to 5 are dropped. In byte 7, bit n enables pair n. In byte 6, bits 0 to 3 enable pairs 8 to 11 and bit 4 enables the feedback output.
- R5: Each byte is shifted in most significant bit first.
- R6: A disabled pair holds both its true pin and its complement pin low. A disabled feedback output is held low.
- R7: While `pwr_dn_n` is low, every true pin, every complement pin and the feedback output are low, whatever the enables hold.
- R8: With `ddr_mode` high, every complement pin of an enabled pair is the inverse of the reference clock. With `ddr_mode` low, the complement pins of pairs 0 to 5 are in phase with the reference clock.
- R9: Enable changes reach the pins only at a falling edge of the reference clock. An output's high pulse is never shortened.
- R10: An address byte with the right seven-bit address but with the read/write bit at 1 is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| smb_scl | input | 1 | Serial bus clock |
| smb_sda_in | input | 1 | Serial bus data, as seen on the wire |
| smb_sda_oe | output | 1 | Pulls the data line low for an acknowledge when high |
| ref_clk_in | input | 1 | Reference clock to be distributed |
| ddr_mode | input | 1 | High: all complements inverted; low: pairs 0-5 complements in phase |
| pwr_dn_n | input | 1 | Active-low power-down; forces all outputs low |
| out_t | output | 12 | True pins of the output pairs |
| out_c | output | 12 | Complement pins of the output pairs |
| fb_out | output | 1 | Feedback clock output |

## Verification
The serial bus inputs pass through a two-stage synchronizer and an edge detector. The acknowledge therefore appears about three system clocks after the bus clock fall that ends a byte. The bench keeps the data line released for a 50 ns quarter bit and reads the acknowledge only at the middle of the following high phase.

The enable bits of the last accepted data byte are stored at that same bus clock fall. They reach the pins at the next falling edge of the reference clock. The scoreboard item is pushed only after three reference periods have passed. The monitor then samples 5 ns after a rising edge of the reference clock and 5 ns after a falling edge, so each sample falls on a stable phase.

A separate watcher records each true pin just after a rising edge of the reference clock and compares it just before the next falling edge. This catches any enable change made during a high phase.

// File: rtl/clk_fanout_pkg.sv
package clk_fanout_pkg;
    localparam int NPAIR      = 12;
    localparam int NSWAP      = 6;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 8;
    localparam logic [6:0] SLAVE_ADDR = 7'b1101001;
    localparam logic [IDX_W-1:0] IDX_LOW_PAIRS  = 8'd7;
    localparam logic [IDX_W-1:0] IDX_HIGH_PAIRS = 8'd6;
    localparam int FB_BIT     = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_COUNT,
        ST_DATA,
        ST_ACK,
        ST_IGNORE
    } smb_state_t;
endpackage

// File: rtl/smb_rx.sv
module smb_rx
    import clk_fanout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    logic [1:0] scl_q, sda_q;
    logic       scl_d, sda_d;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    smb_state_t state_q, state_d, ret_q, after_ack;
    logic [2:0]        bit_cnt;
    logic              byte_done;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] left_q;
    logic [IDX_W-1:0]  idx_q;
    logic              byte_ok;
    logic              receiving;

    assign scl_s    = scl_q[1];
    assign sda_s    = sda_q[1];
    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 2'b11;
            sda_q <= 2'b11;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[0], scl};
            sda_q <= {sda_q[0], sda};
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign receiving = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                       (state_q == ST_COUNT) || (state_q == ST_DATA);

    always_comb begin
        byte_ok   = 1'b0;
        after_ack = ST_DATA;
        unique case (state_q)
            ST_ADDR: begin
                byte_ok   = (shreg[7:1] == SLAVE_ADDR) && !shreg[0];
                after_ack = ST_CMD;
            end
            ST_CMD: begin
                byte_ok   = 1'b1;
                after_ack = ST_COUNT;
            end
            ST_COUNT: byte_ok = 1'b1;
            ST_DATA:  byte_ok = (left_q != '0);
            ST_IDLE, ST_ACK, ST_IGNORE: byte_ok = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (start_c) begin
            state_d = ST_ADDR;
        end else if (stop_c) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR, ST_CMD, ST_COUNT, ST_DATA:
                    if (scl_fall && byte_done)
                        state_d = byte_ok ? ST_ACK : ST_IGNORE;
                ST_ACK:
                    if (scl_fall) state_d = ret_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            byte_done <= 1'b0;
            shreg     <= '0;
            left_q    <= '0;
            idx_q     <= '0;
            ret_q     <= ST_IDLE;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_c || stop_c) begin
                bit_cnt   <= '0;
                byte_done <= 1'b0;
                sda_oe    <= 1'b0;
                idx_q     <= '0;
            end else if (receiving) begin
                if (scl_rise && !byte_done) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) byte_done <= 1'b1;
                end
                if (scl_fall && byte_done) begin
                    byte_done <= 1'b0;
                    bit_cnt   <= '0;
                    if (byte_ok) begin
                        sda_oe <= 1'b1;
                        ret_q  <= after_ack;
                        if (state_q == ST_COUNT) left_q <= shreg;
                        if (state_q == ST_DATA) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= idx_q;
                            wr_data <= shreg;
                            idx_q   <= idx_q + 1'b1;
                            left_q  <= left_q - 1'b1;
                        end
                    end
                end
            end else if (state_q == ST_ACK && scl_fall) begin
                sda_oe <= 1'b0;
            end
        end
    end

    // R2
    ack_on_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R3
    store_only_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state_q == ST_ACK) && sda_oe);
endmodule

// File: rtl/enable_regs.sv
module enable_regs
    import clk_fanout_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NPAIR-1:0]  pair_en,
    output logic              fb_en
);
    localparam int NLOW = BYTE_W;
    localparam int NHIGH = NPAIR - NLOW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_en <= '1;
            fb_en   <= 1'b1;
        end else if (wr_en) begin
            if (wr_idx == IDX_LOW_PAIRS) begin
                pair_en[NLOW-1:0] <= wr_data;
            end else if (wr_idx == IDX_HIGH_PAIRS) begin
                pair_en[NPAIR-1:NLOW] <= wr_data[NHIGH-1:0];
                fb_en <= wr_data[FB_BIT];
            end
        end
    end

    // R4
    low_byte_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_LOW_PAIRS) |=> pair_en[NLOW-1:0] == $past(wr_data));

    // R4
    discard_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx < IDX_HIGH_PAIRS) |=> $stable(pair_en) && $stable(fb_en));
endmodule

// File: rtl/clk_gate_mux.sv
module clk_gate_mux
    import clk_fanout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic             ddr_mode,
    input  logic             pwr_dn_n,
    input  logic [NPAIR-1:0] pair_en,
    input  logic             fb_en,
    output logic [NPAIR-1:0] out_t,
    output logic [NPAIR-1:0] out_c,
    output logic             fb_out
);
    logic [NPAIR-1:0] en_eff;
    logic             fb_eff;

    always_ff @(negedge ref_clk_in or negedge rst_n) begin
        if (!rst_n) begin
            en_eff <= '1;
            fb_eff <= 1'b1;
        end else begin
            en_eff <= pair_en;
            fb_eff <= fb_en;
        end
    end

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        logic inv_c;
        if (i < NSWAP) begin : g_swap
            assign inv_c = ddr_mode;
        end else begin : g_fixed
            assign inv_c = 1'b1;
        end
        assign out_t[i] = pwr_dn_n & en_eff[i] & ref_clk_in;
        assign out_c[i] = pwr_dn_n & en_eff[i] & (inv_c ? ~ref_clk_in : ref_clk_in);
    end

    assign fb_out = pwr_dn_n & fb_eff & ref_clk_in;

    // R9
    no_change_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clk_in && $past(ref_clk_in)) |-> $stable(en_eff) && $stable(fb_eff));

    // R7
    power_down_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |-> (out_t == '0) && (out_c == '0) && !fb_out);

    // R8
    ddr_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr_mode && pwr_dn_n && en_eff[0]) |-> out_c[0] != out_t[0]);
endmodule

// File: rtl/clk_fanout_ctl.sv
module clk_fanout_ctl
    import clk_fanout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smb_scl,
    input  logic             smb_sda_in,
    output logic             smb_sda_oe,
    input  logic             ref_clk_in,
    input  logic             ddr_mode,
    input  logic             pwr_dn_n,
    output logic [NPAIR-1:0] out_t,
    output logic [NPAIR-1:0] out_c,
    output logic             fb_out
);
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [NPAIR-1:0]  pair_en;
    logic              fb_en;

    smb_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (smb_scl),
        .sda     (smb_sda_in),
        .sda_oe  (smb_sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    enable_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .pair_en (pair_en),
        .fb_en   (fb_en)
    );

    clk_gate_mux u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk_in (ref_clk_in),
        .ddr_mode   (ddr_mode),
        .pwr_dn_n   (pwr_dn_n),
        .pair_en    (pair_en),
        .fb_en      (fb_en),
        .out_t      (out_t),
        .out_c      (out_c),
        .fb_out     (fb_out)
    );
endmodule

// File: tb/sim_clk_fanout_ctl.sv
`timescale 1ns/1ps
module sim_clk_fanout_ctl;
    localparam time CLK_PERIOD = 10ns;
    localparam time REF_HALF   = 15ns;
    localparam time QTR        = 50ns;

    typedef struct {
        logic [11:0] th;
        logic [11:0] ch;
        logic [11:0] cl;
        logic        fb;
        string       tag;
    } exp_t;

    logic clk = 0, rst_n = 0, ref_clk = 0;
    logic scl = 1, sda_drv = 1, ddr_mode = 1, pwr_dn_n = 1;
    logic sda_oe, fb_out, sda_line;
    logic [11:0] out_t, out_c;
    int n_chk = 0, n_fail = 0, r9_bad = 0;
    exp_t q[$];

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(REF_HALF) ref_clk = ~ref_clk;

    clk_fanout_ctl u0 (
        .clk(clk), .rst_n(rst_n), .smb_scl(scl), .smb_sda_in(sda_line),
        .smb_sda_oe(sda_oe), .ref_clk_in(ref_clk), .ddr_mode(ddr_mode),
        .pwr_dn_n(pwr_dn_n), .out_t(out_t), .out_c(out_c), .fb_out(fb_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_exp(input logic [11:0] en, input logic fb, input string tag);
        exp_t e;
        logic [11:0] invm;
        invm  = ddr_mode ? 12'hFFF : 12'hFC0;
        e.th  = pwr_dn_n ? en : 12'h000;
        e.ch  = pwr_dn_n ? (en & ~invm) : 12'h000;
        e.cl  = pwr_dn_n ? (en & invm) : 12'h000;
        e.fb  = pwr_dn_n & fb;
        e.tag = tag;
        repeat (3) @(negedge ref_clk);
        q.push_back(e);
        wait (q.size() == 0);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (q.size() > 0);
            e = q[0];
            @(posedge ref_clk); #5;
            check(out_t == e.th, {e.tag, " true high"}, 32'(out_t), 32'(e.th));
            check(out_c == e.ch, {e.tag, " comp high"}, 32'(out_c), 32'(e.ch));
            check(fb_out == e.fb, {e.tag, " fb high"}, 32'(fb_out), 32'(e.fb));
            @(negedge ref_clk); #5;
            check(out_t == 12'h000, {e.tag, " true low"}, 32'(out_t), 32'h0);
            check(out_c == e.cl, {e.tag, " comp low"}, 32'(out_c), 32'(e.cl));
            check(fb_out == 1'b0, {e.tag, " fb low"}, 32'(fb_out), 32'h0);
            void'(q.pop_front());
        end
    end

    // R9 watcher: a true pin seen high after a rise must stay high until the fall
    initial begin : r9_watch
        logic [11:0] cap;
        logic pd;
        forever begin
            @(posedge ref_clk); #1;
            cap = out_t; pd = pwr_dn_n;
            #(REF_HALF - 2ns);
            if (pd == pwr_dn_n && pd && out_t != cap) r9_bad++;
        end
    end

    task automatic smb_start();
        sda_drv = 1; scl = 1; #QTR;
        sda_drv = 0; #QTR;
        scl = 0; #QTR;
    endtask

    task automatic smb_stop();
        sda_drv = 0; #QTR;
        scl = 1; #QTR;
        sda_drv = 1; #QTR;
    endtask

    task automatic smb_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; #QTR;
            scl = 1; #(2*QTR);
            scl = 0; #QTR;
        end
        sda_drv = 1; #QTR;
        scl = 1; #QTR;
        acked = !sda_line;
        #QTR;
        scl = 0; #QTR;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : driver
        bit a;
        #(CLK_PERIOD * 5);
        rst_n = 1;
        #(CLK_PERIOD * 5);
        // R1: reset state, all enabled
        push_exp(12'hFFF, 1'b1, "R1 reset");

        // R2 R3 R4 R5 R6: full block write
        smb_start();
        smb_byte(8'hD2, a); check(a, "R2 address ack", 32'(a), 32'h1);
        smb_byte(8'h00, a); check(a, "R3 command ack", 32'(a), 32'h1);
        smb_byte(8'h08, a); check(a, "R3 count ack", 32'(a), 32'h1);
        for (int k = 0; k < 6; k++) begin
            smb_byte(8'h00, a); check(a, "R3 data ack", 32'(a), 32'h1);
        end
        smb_byte(8'h0A, a); check(a, "R3 byte6 ack", 32'(a), 32'h1);
        smb_byte(8'hA5, a); check(a, "R3 byte7 ack", 32'(a), 32'h1);
        smb_stop();
        push_exp(12'hAA5, 1'b0, "R4 R5 R6 write");

        // R8: swapped complements
        ddr_mode = 0;
        push_exp(12'hAA5, 1'b0, "R8 sdram mode");
        ddr_mode = 1;
        push_exp(12'hAA5, 1'b0, "R8 ddr mode");

        // R2: wrong address
        smb_start();
        smb_byte(8'hD4, a); check(!a, "R2 wrong address nak", 32'(a), 32'h0);
        smb_byte(8'h00, a);
        smb_byte(8'h00, a);
        smb_stop();
        push_exp(12'hAA5, 1'b0, "R2 no change");

        // R10: read direction refused
        smb_start();
        smb_byte(8'hD3, a); check(!a, "R10 read nak", 32'(a), 32'h0);
        smb_stop();

        // R3: count exhausted before byte 7
        smb_start();
        smb_byte(8'hD2, a);
        smb_byte(8'h00, a);
        smb_byte(8'h07, a); check(a, "R3 count ack", 32'(a), 32'h1);
        for (int k = 0; k < 6; k++) smb_byte(8'hFF, a);
        smb_byte(8'h1F, a); check(a, "R3 last counted ack", 32'(a), 32'h1);
        smb_byte(8'h00, a); check(!a, "R3 beyond count nak", 32'(a), 32'h0);
        smb_stop();
        push_exp(12'hFA5, 1'b1, "R3 R4 partial");

        // R7: power-down
        pwr_dn_n = 0;
        push_exp(12'hFA5, 1'b1, "R7 power down");
        pwr_dn_n = 1;
        push_exp(12'hFA5, 1'b1, "R7 power up");

        check(r9_bad == 0, "R9 no shortened pulse", 32'(r9_bad), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule